// File: doc/BRIEF.md
# Peripheral Clock and Access Gating Unit

This block lets software power down peripherals one at a time. It keeps a bank of module-disable registers on a simple byte-wide register bus, with one bit for each peripheral. For every peripheral it drives a clock enable and a function-active flag. It also decides whether a bus access addressed to that peripheral is forwarded or blocked.

Each peripheral also reports the functional enable bit that sits in its own control register. That bit gives a lighter off state: the peripheral stops working, but its registers remain reachable. Setting the disable bit gives the deeper state. The clock is withdrawn, writes are dropped and reads return zero. When a disable bit is cleared, the peripheral gets a one-cycle reset pulse in the same cycle its clock returns, because its register contents were lost while it was disabled.

The bus address selects the target. When the top bit is set, the access goes to the disable bank and the low bits pick the bank register. When the top bit is clear, the middle bits pick the peripheral and the low bits pick the register inside it.

Top module: `pmd_gating_unit`

## Requirements
- R1: After reset every disable bit is 0, every per_clk_en bit is 1, per_rst is all zero, and all four bank registers read back as 0x00.
- R2: A write with bus_addr[8]=1 loads bus_wdata into bank register bus_addr[1:0], which holds the disable bits of peripherals 8*r to 8*r+7 (bit k = peripheral 8*r+k). The new value is visible from the cycle after the write edge. A read with bus_addr[8]=1 returns that register.
- R3: per_clk_en[p] is the inverse of peripheral p's disable bit.
- R4: per_active[p] is 1 exactly when per_func_en[p] is 1 and peripheral p's disable bit is 0.
- R5: A write with bus_addr[8]=0 targets peripheral bus_addr[7:3] and register bus_addr[2:0]. It raises only that peripheral's per_wr bit, in the same cycle, and only if the peripheral is not disabled. Otherwise per_wr stays all zero.
- R6: A read of a disabled peripheral returns 0x00 on bus_rdata and raises no per_rd bit.
- R7: A read of an enabled peripheral raises only its per_rd bit and returns its byte of per_rdata (bits 8*p+7 down to 8*p) in the same cycle.
- R8: Clearing a disable bit raises that peripheral's per_rst bit for exactly one cycle, starting the cycle after the write edge, which is also the first cycle its clock enable is back. Setting a disable bit produces no pulse.
- R9: A clear per_func_en bit does not block register access: writes and reads to that peripheral pass while its disable bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 9 | Bus address: bank select bit, peripheral index, register index |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high, zero otherwise |
| per_func_en | input | 32 | Functional enable bit from each peripheral |
| per_rdata | input | 256 | Read data from each peripheral, one byte per peripheral |
| per_clk_en | output | 32 | Clock enable for each peripheral |
| per_active | output | 32 | Peripheral is clocked and functionally enabled |
| per_wr | output | 32 | Forwarded write strobe, one per peripheral |
| per_rd | output | 32 | Forwarded read strobe, one per peripheral |
| per_reg_addr | output | 3 | Register index inside the peripheral |
| per_wdata | output | 8 | Write data forwarded to peripherals |
| per_rst | output | 32 | One-cycle reset pulse when a peripheral is re-enabled |

## Verification
The assertions check several rules on every cycle. No forwarded strobe reaches a peripheral whose clock is off. At most one write strobe is high. The active flag never appears without a clock. A read of a disabled peripheral returns zero. A bank write lands in the matching clock enables one cycle later. Each re-enable pulse lasts one cycle and coincides with the clock returning. The bench scenarios show what no single-cycle property can: bank read-back, the exact byte routed from an enabled peripheral, and access that continues while the functional enable is clear. They also walk every peripheral with a mixed disable pattern and compare against a reference model on every clock.

// File: rtl/pmd_pkg.sv
package pmd_pkg;

    // Kind of bus access decoded from the address
    typedef enum logic [1:0] {
        ACC_IDLE   = 2'd0,
        ACC_BANK   = 2'd1,
        ACC_PERIPH = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/pmd_bus_decode.sv
module pmd_bus_decode
    import pmd_pkg::*;
#(
    parameter int BIDX_W = 2,
    parameter int PIDX_W = 5,
    parameter int PREG_W = 3,
    localparam int ADDR_W = 1 + PIDX_W + PREG_W
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output acc_kind_e         acc_kind,
    output logic [BIDX_W-1:0] bank_idx,
    output logic [PIDX_W-1:0] per_idx,
    output logic [PREG_W-1:0] reg_addr,
    output logic              bank_wr,
    output logic              per_wr_req,
    output logic              per_rd_req
);
    logic bank_sel;

    always_comb begin
        bank_sel   = bus_addr[ADDR_W-1];
        bank_idx   = bus_addr[BIDX_W-1:0];
        per_idx    = bus_addr[PREG_W +: PIDX_W];
        reg_addr   = bus_addr[PREG_W-1:0];
        bank_wr    = bus_wr & bank_sel;
        per_wr_req = bus_wr & ~bank_sel;
        per_rd_req = bus_rd & ~bank_sel;
        if (!(bus_wr | bus_rd)) begin
            acc_kind = ACC_IDLE;
        end else if (bank_sel) begin
            acc_kind = ACC_BANK;
        end else begin
            acc_kind = ACC_PERIPH;
        end
    end
endmodule

// File: rtl/pmd_regbank.sv
module pmd_regbank #(
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 8,
    localparam int NUM_PERIPH = NUM_REGS * REG_W,
    localparam int BIDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bank_wr,
    input  logic [BIDX_W-1:0]     bank_idx,
    input  logic [REG_W-1:0]      wdata,
    output logic [NUM_PERIPH-1:0] dis_bits,
    output logic [NUM_PERIPH-1:0] wake_pulse,
    output logic [REG_W-1:0]      bank_rdata
);
    typedef struct packed {
        logic [NUM_PERIPH-1:0] dis;
        logic [NUM_PERIPH-1:0] wake;
    } bank_state_t;

    bank_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (bank_wr) begin
            state_d.dis[bank_idx*REG_W +: REG_W] = wdata;
        end
        // a bit going from disabled to enabled requests a reset pulse
        state_d.wake = state_q.dis & ~state_d.dis;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign dis_bits   = state_q.dis;
    assign wake_pulse = state_q.wake;
    assign bank_rdata = state_q.dis[bank_idx*REG_W +: REG_W];
endmodule

// File: rtl/pmd_gate_slot.sv
module pmd_gate_slot (
    input  logic dis,
    input  logic func_en,
    input  logic sel,
    input  logic wr_req,
    input  logic rd_req,
    output logic clk_en,
    output logic active,
    output logic wr_stb,
    output logic rd_stb
);
    always_comb begin
        clk_en = ~dis;
        active = clk_en & func_en;
        wr_stb = clk_en & sel & wr_req;
        rd_stb = clk_en & sel & rd_req;
    end
endmodule

// File: rtl/pmd_gating_unit.sv
module pmd_gating_unit
    import pmd_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 8,
    parameter int PREG_W   = 3,
    localparam int NUM_PERIPH = NUM_REGS * REG_W,
    localparam int PIDX_W     = $clog2(NUM_PERIPH),
    localparam int BIDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int ADDR_W     = 1 + PIDX_W + PREG_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [REG_W-1:0]            bus_wdata,
    output logic [REG_W-1:0]            bus_rdata,
    input  logic [NUM_PERIPH-1:0]       per_func_en,
    input  logic [NUM_PERIPH*REG_W-1:0] per_rdata,
    output logic [NUM_PERIPH-1:0]       per_clk_en,
    output logic [NUM_PERIPH-1:0]       per_active,
    output logic [NUM_PERIPH-1:0]       per_wr,
    output logic [NUM_PERIPH-1:0]       per_rd,
    output logic [PREG_W-1:0]           per_reg_addr,
    output logic [REG_W-1:0]            per_wdata,
    output logic [NUM_PERIPH-1:0]       per_rst
);
    acc_kind_e             acc_kind;
    logic [BIDX_W-1:0]     bank_idx;
    logic [PIDX_W-1:0]     per_idx;
    logic                  bank_wr;
    logic                  per_wr_req;
    logic                  per_rd_req;
    logic [NUM_PERIPH-1:0] dis_bits;
    logic [REG_W-1:0]      bank_rdata;

    pmd_bus_decode #(
        .BIDX_W(BIDX_W),
        .PIDX_W(PIDX_W),
        .PREG_W(PREG_W)
    ) u_decode (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .acc_kind  (acc_kind),
        .bank_idx  (bank_idx),
        .per_idx   (per_idx),
        .reg_addr  (per_reg_addr),
        .bank_wr   (bank_wr),
        .per_wr_req(per_wr_req),
        .per_rd_req(per_rd_req)
    );

    pmd_regbank #(
        .NUM_REGS(NUM_REGS),
        .REG_W   (REG_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_wr   (bank_wr),
        .bank_idx  (bank_idx),
        .wdata     (bus_wdata),
        .dis_bits  (dis_bits),
        .wake_pulse(per_rst),
        .bank_rdata(bank_rdata)
    );

    for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_slot
        pmd_gate_slot u_slot (
            .dis    (dis_bits[p]),
            .func_en(per_func_en[p]),
            .sel    (per_idx == PIDX_W'(p)),
            .wr_req (per_wr_req),
            .rd_req (per_rd_req),
            .clk_en (per_clk_en[p]),
            .active (per_active[p]),
            .wr_stb (per_wr[p]),
            .rd_stb (per_rd[p])
        );
    end

    assign per_wdata = bus_wdata;

    // read data: bank contents, or the addressed peripheral's byte if it is clocked
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (acc_kind)
                ACC_BANK:   bus_rdata = bank_rdata;
                ACC_PERIPH: begin
                    if (per_clk_en[per_idx]) begin
                        bus_rdata = per_rdata[per_idx*REG_W +: REG_W];
                    end
                end
                default:    bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pmd_gating_checker.sv
module pmd_gating_checker #(
    parameter int NUM_REGS = 4,
    parameter int REG_W    = 8,
    parameter int PREG_W   = 3,
    localparam int NUM_PERIPH = NUM_REGS * REG_W,
    localparam int PIDX_W     = $clog2(NUM_PERIPH),
    localparam int BIDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int ADDR_W     = 1 + PIDX_W + PREG_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [REG_W-1:0]      bus_wdata,
    input logic [REG_W-1:0]      bus_rdata,
    input logic [NUM_PERIPH-1:0] per_clk_en,
    input logic [NUM_PERIPH-1:0] per_active,
    input logic [NUM_PERIPH-1:0] per_wr,
    input logic [NUM_PERIPH-1:0] per_rd,
    input logic [NUM_PERIPH-1:0] per_rst
);
    logic              bank_wr_q;
    logic [BIDX_W-1:0] bank_idx_q;
    logic [REG_W-1:0]  bank_data_q;
    logic [PIDX_W-1:0] tgt;

    assign tgt = bus_addr[PREG_W +: PIDX_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_wr_q   <= 1'b0;
            bank_idx_q  <= '0;
            bank_data_q <= '0;
        end else begin
            bank_wr_q   <= bus_wr & bus_addr[ADDR_W-1];
            bank_idx_q  <= bus_addr[BIDX_W-1:0];
            bank_data_q <= bus_wdata;
        end
    end

    AST_BANK_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr_q |-> (per_clk_en[bank_idx_q*REG_W +: REG_W] == ~bank_data_q)); // R2
    AST_ACTIVE_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (per_active & ~per_clk_en) == '0); // R4
    AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(per_wr)); // R5
    AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (per_wr & ~per_clk_en) == '0); // R5
    AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (per_rd & ~per_clk_en) == '0); // R6
    AST_DIS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_addr[ADDR_W-1] && !per_clk_en[tgt]) |-> (bus_rdata == '0)); // R6
    AST_WAKE_AFTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (per_rst & $past(per_clk_en)) == '0); // R8
    AST_WAKE_CLK_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (per_rst & ~per_clk_en) == '0); // R8
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (per_rst & $past(per_rst)) == '0); // R8
endmodule

bind pmd_gating_unit pmd_gating_checker #(
    .NUM_REGS(NUM_REGS),
    .REG_W   (REG_W),
    .PREG_W  (PREG_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .per_clk_en(per_clk_en),
    .per_active(per_active),
    .per_wr    (per_wr),
    .per_rd    (per_rd),
    .per_rst   (per_rst)
);

// File: tb/pmd_gating_unit_tb.sv
module pmd_gating_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [8:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [7:0]   bus_wdata = '0;
    logic [7:0]   bus_rdata;
    logic [31:0]  per_func_en = '0;
    logic [255:0] per_rdata;
    logic [31:0]  per_clk_en, per_active, per_wr, per_rd, per_rst;
    logic [2:0]   per_reg_addr;
    logic [7:0]   per_wdata;

    int checks = 0;
    int failures = 0;

    // reference model state
    logic [31:0] m_dis = '0;
    logic [31:0] m_rst = '0;

    always #2 clk = ~clk;  // 250 MHz

    function automatic logic [7:0] pat(input int p);
        return 8'((p * 13 + 7) & 255);
    endfunction

    always_comb begin
        for (int p = 0; p < 32; p++) per_rdata[p*8 +: 8] = pat(p);
    end

    pmd_gating_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .per_func_en(per_func_en), .per_rdata(per_rdata),
        .per_clk_en(per_clk_en), .per_active(per_active), .per_wr(per_wr),
        .per_rd(per_rd), .per_reg_addr(per_reg_addr), .per_wdata(per_wdata),
        .per_rst(per_rst)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural reference, advanced on every clock
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dis <= '0;
            m_rst <= '0;
        end else begin
            logic [31:0] nxt;
            nxt = m_dis;
            if (bus_wr && bus_addr[8]) nxt[int'(bus_addr[1:0])*8 +: 8] = bus_wdata;
            m_rst <= m_dis & ~nxt;
            m_dis <= nxt;
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            int p;
            logic [31:0] e_wr, e_rd;
            logic [7:0]  e_rdata;
            p = int'(bus_addr[7:3]);
            e_wr = (bus_wr && !bus_addr[8] && !m_dis[p]) ? (32'd1 << p) : 32'd0;
            e_rd = (bus_rd && !bus_addr[8] && !m_dis[p]) ? (32'd1 << p) : 32'd0;
            e_rdata = 8'd0;
            if (bus_rd) begin
                if (bus_addr[8]) e_rdata = m_dis[int'(bus_addr[1:0])*8 +: 8];
                else if (!m_dis[p]) e_rdata = pat(p);
            end
            chk("R3", "cyc clk_en", per_clk_en, ~m_dis);
            chk("R4", "cyc active", per_active, per_func_en & ~m_dis);
            chk("R5", "cyc per_wr", per_wr, e_wr);
            chk("R6", "cyc per_rd", per_rd, e_rd);
            chk("R7", "cyc rdata", 32'(bus_rdata), 32'(e_rdata));
            chk("R8", "cyc per_rst", per_rst, m_rst);
        end
    end

    // all tasks start and end at posedge + 1
    task automatic bus_write(input logic [8:0] a, input logic [7:0] d,
                             output logic [31:0] stb);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #1 stb = per_wr;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [8:0] a, output logic [7:0] d,
                            output logic [31:0] stb);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata; stb = per_rd;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    function automatic logic [8:0] bank_a(input int r);
        return 9'h100 | 9'(r);
    endfunction

    function automatic logic [8:0] per_a(input int p, input int k);
        return 9'((p << 3) | k);
    endfunction

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [31:0] s;
        logic [31:0] exp_dis;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "clk_en in reset", per_clk_en, 32'hFFFF_FFFF);
        chk("R1", "per_rst in reset", per_rst, 32'h0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        for (int r = 0; r < 4; r++) begin
            bus_read(bank_a(r), d, s);
            chk("R1", "bank reset value", 32'(d), 32'h0);
        end

        // R2: load two bank registers, read them back
        bus_write(bank_a(0), 8'h05, s);
        bus_write(bank_a(2), 8'hF0, s);
        chk("R3", "clk_en after bank writes", per_clk_en, ~32'h00F0_0005);
        bus_read(bank_a(0), d, s);
        chk("R2", "bank0 readback", 32'(d), 32'h05);
        bus_read(bank_a(2), d, s);
        chk("R2", "bank2 readback", 32'(d), 32'hF0);
        bus_write(bank_a(1), 8'h81, s);
        bus_read(bank_a(1), d, s);
        chk("R2", "bank1 readback", 32'(d), 32'h81);
        bus_write(bank_a(1), 8'h00, s);

        // R4: function-active combinations
        per_func_en = 32'hFFFF_FFFF;
        #1 chk("R4", "active all func", per_active, ~32'h00F0_0005);
        per_func_en = 32'h0000_000F;
        #1 chk("R4", "active low nibble", per_active, 32'h0000_000A);

        // R5: writes to disabled and enabled peripherals
        bus_write(per_a(0, 2), 8'h3C, s);
        chk("R5", "write to disabled p0", s, 32'h0);
        bus_write(per_a(1, 2), 8'h3C, s);
        chk("R5", "write to enabled p1", s, 32'h0000_0002);

        // R9: functional enable clear, access still passes
        per_func_en = 32'h0;
        bus_write(per_a(1, 5), 8'hA5, s);
        chk("R9", "write with func off", s, 32'h0000_0002);
        bus_read(per_a(1, 5), d, s);
        chk("R9", "read with func off", 32'(d), 32'(pat(1)));

        // R6 / R7: reads
        bus_read(per_a(2, 0), d, s);
        chk("R6", "read disabled p2 data", 32'(d), 32'h0);
        chk("R6", "read disabled p2 strobe", s, 32'h0);
        bus_read(per_a(20, 1), d, s);
        chk("R6", "read disabled p20 data", 32'(d), 32'h0);
        bus_read(per_a(3, 7), d, s);
        chk("R7", "read enabled p3 data", 32'(d), 32'(pat(3)));
        chk("R7", "read enabled p3 strobe", s, 32'h0000_0008);

        // R8: wake pulse on clear, none on set
        bus_write(bank_a(0), 8'h04, s);
        chk("R8", "wake pulse p0", per_rst, 32'h0000_0001);
        chk("R8", "clk back p0", 32'(per_clk_en[0]), 32'h1);
        @(posedge clk); #1;
        chk("R8", "wake pulse ends", per_rst, 32'h0);
        bus_write(bank_a(0), 8'h05, s);
        chk("R8", "no pulse on set", per_rst, 32'h0);
        bus_write(bank_a(2), 8'h00, s);
        chk("R8", "wake pulse bank2", per_rst, 32'h00F0_0000);

        // walk every peripheral with a mixed pattern
        bus_write(bank_a(3), 8'hFF, s);
        exp_dis = 32'hFF00_0005;
        for (int p = 0; p < 32; p++) begin
            bus_read(per_a(p, p & 7), d, s);
            if (exp_dis[p]) chk("R6", "walk disabled read", 32'(d), 32'h0);
            else            chk("R7", "walk enabled read", 32'(d), 32'(pat(p)));
        end
        repeat (2) @(posedge clk);
        #1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule